// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an ALU and turns each finished operation into a set of status flags. It receives the operation class, the operand width (8, 16 or 32 bits), both operands, the incoming carry, the raw result, and for shifts the last bit that was pushed out. From these it works out the sign, zero, parity, auxiliary carry, carry and overflow flags at the selected width. The ALU datapath itself and any branching on the flags are outside this block.

The flags are kept in a 16-bit register. The same register also holds three control bits: string step direction, external interrupt enable and single-step trap. These are written through their own small control port. A status update happens on a clock edge with the update strobe high. A control write in the same cycle changes only its own bit, and that bit has priority.

There is no sequencing state. One register stage holds the flags, and the flag logic in front of it is purely combinational.

Top module: `arith_flag_unit`

## Requirements
- R1: During and after reset the flag word reads 0, except the interrupt enable bit (bit 9), which takes the parameter INTR_RST.
- R2: Flag word layout: carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt bit 9, direction bit 10, overflow bit 11. Every other bit always reads 0.
- R3: Width and sign/zero rules:
  - Width select `op_size`: 0 means 8 bits, 1 means 16 bits, 2 or 3 means 32 bits.
  - Sign is the result bit at width-1.
  - Zero is 1 exactly when the result bits below the width are all 0.
- R4: Parity is 1 when the low 8 result bits hold an odd number of ones, and 0 when they hold an even number.
- R5: Add (`op_kind`=0) computes a+b+carry_in at the width:
  - Carry is the carry out of the top bit.
  - Overflow is 1 when both operands have the same sign and the result sign differs from it.
- R6: Subtract (`op_kind`=1) computes a-b-carry_in:
  - Carry is 1 on a borrow, i.e. when a < b+carry_in unsigned at the width.
  - Overflow is 1 when the operand signs differ and the result sign differs from a.
- R7: For add and subtract, the auxiliary flag equals a[4]^b[4]^result[4], which is the carry or borrow from bit 3 into bit 4.
- R8: Logic (`op_kind`=2) clears carry and overflow, keeps the auxiliary flag, and updates sign, zero and parity.
- R9: Shift/rotate (`op_kind`=3) behaviour:
  - Carry is loaded from `shift_last`.
  - Overflow and auxiliary are kept.
  - Sign, zero and parity are updated.
- R10: With `upd_en` low, the status flags keep their value whatever the operand inputs do.
- R11: Control port writes:
  - When `ctl_we` is high, `ctl_sel` 0 writes direction, 1 writes interrupt enable, 2 writes trap. The value comes from `ctl_val`.
  - `ctl_sel` 3 changes nothing.
  - With `ctl_we` low, the control bits hold their value.
- R12: A control write and a status update in the same cycle both take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Status flag update strobe |
| op_kind | input | 2 | 0 add, 1 subtract, 2 logic, 3 shift/rotate |
| op_size | input | 2 | 0 8-bit, 1 16-bit, 2/3 32-bit |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Incoming carry/borrow for add/subtract |
| result | input | 32 | Raw ALU result |
| shift_last | input | 1 | Last bit shifted or rotated out |
| ctl_we | input | 1 | Control bit write enable |
| ctl_sel | input | 2 | 0 direction, 1 interrupt enable, 2 trap, 3 none |
| ctl_val | input | 1 | Value written to the selected control bit |
| flags | output | 16 | Flag word |

## Verification
The bench builds the block with INTR_RST set to 1 rather than the default 0. This shows that the reset value of the interrupt enable bit follows the parameter, while every other bit resets to zero. DATA_W stays at 32, so all three width slices are generated and each one is reached through `op_size`. Boundary cases cover:
- signed overflow at each width;
- borrow with a nonzero `carry_in`;
- results that are zero only at the narrow width.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

    typedef enum logic [1:0] {
        OPK_ADD   = 2'd0,
        OPK_SUB   = 2'd1,
        OPK_LOGIC = 2'd2,
        OPK_SHIFT = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        CSEL_DIR  = 2'd0,
        CSEL_INT  = 2'd1,
        CSEL_TRAP = 2'd2,
        CSEL_NONE = 2'd3
    } csel_e;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } stat_t;

endpackage

// File: rtl/aflag_width_calc.sv
module aflag_width_calc
    import aflag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         cin,
    input  logic         is_sub,
    output logic         sgn,
    output logic         zro,
    output logic         cry,
    output logic         ovf
);

    logic [W:0] ext;

    always_comb begin
        if (is_sub)
            ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    always_comb begin
        sgn = r[W-1];
        zro = ~|r;
        cry = ext[W];
        if (is_sub)
            ovf = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        else
            ovf = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    end

endmodule

// File: rtl/aflag_calc.sv
module aflag_calc
    import aflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opk_e              kind,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] r,
    input  logic              cin,
    input  logic              shl,
    input  stat_t             cur,
    output stat_t             nxt
);

    localparam int NSIZE = $clog2(DATA_W / 8) + 1;
    localparam logic [1:0] LAST = 2'(NSIZE - 1);

    logic [NSIZE-1:0] sgn_w, zro_w, cry_w, ovf_w;
    logic [1:0]       idx;
    logic             is_sub;
    logic             sgn_s, zro_s, cry_s, ovf_s, par_s, aux_s;

    assign is_sub = (kind == OPK_SUB);

    for (genvar g = 0; g < NSIZE; g++) begin : g_width
        localparam int WG = 8 << g;
        aflag_width_calc #(.W(WG)) u_wc (
            .a      (a[WG-1:0]),
            .b      (b[WG-1:0]),
            .r      (r[WG-1:0]),
            .cin    (cin),
            .is_sub (is_sub),
            .sgn    (sgn_w[g]),
            .zro    (zro_w[g]),
            .cry    (cry_w[g]),
            .ovf    (ovf_w[g])
        );
    end

    always_comb begin
        idx   = (size > LAST) ? LAST : size;
        sgn_s = sgn_w[idx];
        zro_s = zro_w[idx];
        cry_s = cry_w[idx];
        ovf_s = ovf_w[idx];
        par_s = ^r[7:0];
        aux_s = a[4] ^ b[4] ^ r[4];
    end

    always_comb begin
        nxt     = cur;
        nxt.sgn = sgn_s;
        nxt.zro = zro_s;
        nxt.par = par_s;
        unique case (kind)
            OPK_ADD, OPK_SUB: begin
                nxt.cry = cry_s;
                nxt.ovf = ovf_s;
                nxt.aux = aux_s;
            end
            OPK_LOGIC: begin
                nxt.cry = 1'b0;
                nxt.ovf = 1'b0;
            end
            OPK_SHIFT: begin
                nxt.cry = shl;
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/aflag_store.sv
module aflag_store
    import aflag_pkg::*;
#(
    parameter logic INTR_RST = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_en,
    input  stat_t       stat_nxt,
    input  logic        ctl_we,
    input  csel_e       ctl_sel,
    input  logic        ctl_val,
    output stat_t       stat_q,
    output logic [15:0] word
);

    logic df_q, if_q, tf_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (upd_en)
            stat_q <= stat_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            df_q <= 1'b0;
            if_q <= INTR_RST;
            tf_q <= 1'b0;
        end else if (ctl_we) begin
            unique case (ctl_sel)
                CSEL_DIR:  df_q <= ctl_val;
                CSEL_INT:  if_q <= ctl_val;
                CSEL_TRAP: tf_q <= ctl_val;
                CSEL_NONE: ;
                default:   ;
            endcase
        end
    end

    always_comb begin
        word         = '0;
        word[POS_CF] = stat_q.cry;
        word[POS_PF] = stat_q.par;
        word[POS_AF] = stat_q.aux;
        word[POS_ZF] = stat_q.zro;
        word[POS_SF] = stat_q.sgn;
        word[POS_TF] = tf_q;
        word[POS_IF] = if_q;
        word[POS_DF] = df_q;
        word[POS_OF] = stat_q.ovf;
    end

    assert_hold_stat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(stat_q));

    assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable({df_q, if_q, tf_q}));

    assert_ctl_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_sel == CSEL_DIR) |=> df_q == $past(ctl_val));

    assert_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_sel == CSEL_TRAP && upd_en) |=> (tf_q == $past(ctl_val)) && (stat_q == $past(stat_nxt)));

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import aflag_pkg::*;
#(
    parameter int   DATA_W   = 32,
    parameter logic INTR_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] result,
    input  logic              shift_last,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_sel,
    input  logic              ctl_val,
    output logic [15:0]       flags
);

    stat_t stat_q, stat_nxt;

    aflag_calc #(.DATA_W(DATA_W)) u_calc (
        .kind (opk_e'(op_kind)),
        .size (op_size),
        .a    (opnd_a),
        .b    (opnd_b),
        .r    (result),
        .cin  (carry_in),
        .shl  (shift_last),
        .cur  (stat_q),
        .nxt  (stat_nxt)
    );

    aflag_store #(.INTR_RST(INTR_RST)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .stat_nxt (stat_nxt),
        .ctl_we   (ctl_we),
        .ctl_sel  (csel_e'(ctl_sel)),
        .ctl_val  (ctl_val),
        .stat_q   (stat_q),
        .word     (flags)
    );

    assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind == 2'd2) |=> !flags[POS_CF] && !flags[POS_OF] && $stable(flags[POS_AF]));

    assert_shift_cf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind == 2'd3) |=> flags[POS_CF] == $past(shift_last) && $stable(flags[POS_OF]));

    assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags[POS_ZF] |-> !flags[POS_SF]);

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & 16'hF02A) == 16'h0000);

endmodule

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result = '0;
    logic        shift_last = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_sel = '0;
    logic        ctl_val = 1'b0;
    logic [15:0] flags;

    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] model = 16'h0200;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    arith_flag_unit #(.DATA_W(32), .INTR_RST(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_kind(op_kind), .op_size(op_size),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .result(result),
        .shift_last(shift_last), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_val(ctl_val),
        .flags(flags)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flags=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference: result and next flag word from the requirements
    task automatic drive(input string tag, input logic [1:0] k, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b, input logic ci,
                         input logic sl, input logic upd, input logic we,
                         input logic [1:0] sel, input logic val);
        int          w;
        logic [63:0] m, am, bm, t, res;
        logic        sa, sb, sr;
        logic [15:0] nx;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (64'd1 << w) - 64'd1;
        am = {32'd0, a} & m;
        bm = {32'd0, b} & m;
        nx = model;
        case (k)
            2'd0: t = am + bm + {63'd0, ci};
            2'd1: t = am - bm - {63'd0, ci};
            2'd2: t = (am ^ bm) & m;
            default: t = ((am << 1) | {63'd0, ci}) & m;
        endcase
        res = t & m;
        sa = am[w-1]; sb = bm[w-1]; sr = res[w-1];
        if (upd) begin
            nx[7] = sr;
            nx[6] = (res == 64'd0);
            nx[2] = ^res[7:0];
            if (k == 2'd0) begin
                nx[0]  = t[w];
                nx[11] = (sa == sb) && (sr != sa);
                nx[4]  = am[4] ^ bm[4] ^ res[4];
            end else if (k == 2'd1) begin
                nx[0]  = (am < bm + {63'd0, ci});
                nx[11] = (sa != sb) && (sr != sa);
                nx[4]  = am[4] ^ bm[4] ^ res[4];
            end else if (k == 2'd2) begin
                nx[0] = 1'b0; nx[11] = 1'b0;
            end else begin
                nx[0] = sl;
            end
        end
        if (we) begin
            if (sel == 2'd0) nx[10] = val;
            if (sel == 2'd1) nx[9]  = val;
            if (sel == 2'd2) nx[8]  = val;
        end
        @(negedge clk);
        op_kind = k; op_size = sz; opnd_a = a; opnd_b = b; carry_in = ci;
        result = res[31:0]; shift_last = sl; upd_en = upd;
        ctl_we = we; ctl_sel = sel; ctl_val = val;
        model = nx;
        exp_q.push_back(nx);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    // monitor: compares one expected word per edge after it settles
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), flags, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: flags=%h expected=done", flags);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", flags, 16'h0200);
        @(negedge clk);
        rst_n = 1'b1;
        // R5 add overflow at 8 bits, R7 aux carry
        drive("R5 add 8b ovf", 2'd0, 2'd0, 32'h7F, 32'h01, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R5 add 8b carry zero", 2'd0, 2'd0, 32'hFF, 32'h01, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R3 add 16b upper bits ignored", 2'd0, 2'd1, 32'hABCD_8000, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R5 add 32b with carry_in", 2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R5 add 32b ovf size3", 2'd0, 2'd3, 32'h7FFF_0000, 32'h0001_0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        // R6 subtract
        drive("R6 sub borrow", 2'd1, 2'd0, 32'h10, 32'h10, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R6 sub ovf 16b", 2'd1, 2'd1, 32'h8000, 32'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R7 sub aux borrow", 2'd1, 2'd0, 32'h20, 32'h01, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R4 parity even", 2'd0, 2'd2, 32'h0000_0100, 32'h03, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        // R8 logic keeps aux
        drive("R7 aux set", 2'd0, 2'd0, 32'h0F, 32'h01, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R8 logic", 2'd2, 2'd0, 32'hF0, 32'h0F, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R3 logic zero", 2'd2, 2'd1, 32'h1234, 32'h1234, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        // R9 shift
        drive("R5 setup ovf", 2'd0, 2'd0, 32'h40, 32'h40, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R9 shift cf", 2'd3, 2'd0, 32'h81, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
        drive("R9 shift cf0", 2'd3, 2'd1, 32'h4000, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        // R10 no update
        drive("R10 hold", 2'd0, 2'd0, 32'hFF, 32'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        drive("R10 hold sub", 2'd1, 2'd2, 32'h0, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        // R11 control port
        drive("R11 dir set", 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1);
        drive("R11 int clear", 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
        drive("R11 trap set", 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1);
        drive("R11 sel3 ignored", 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0);
        drive("R11 we low holds", 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        // R12 both in one cycle; R2 layout across all
        drive("R12 update+ctl", 2'd1, 2'd0, 32'h00, 32'h01, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1);
        drive("R2 full word", 2'd0, 2'd0, 32'h80, 32'h80, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0);
        @(negedge clk);
        upd_en = 1'b0; ctl_we = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule